// File: doc/BRIEF.md
# Synchronous Receive Hunt Logic

This block is the character-synchronization front end of a serial receiver. It runs in the receive clock domain and advances on every rising edge of that clock. In character-oriented modes it hunts for synchronization in the incoming bit stream and then cuts the stream into characters, which it presents with a one-cycle strobe. It matches either one 8-bit sync pattern or two patterns back to back. In external-sync mode it takes synchronization from a strobe on the SYNC pin instead.

The SYNC pin is bidirectional and active low, and its role follows the mode:
- In start-stop mode it is a status input. A change of level latches a status bit and raises an external/status interrupt request.
- In internal character sync it is an output. It pulses low for one clock each time a sync pattern is recognized.
- In external sync its falling edge ends the hunt.
- In bit-oriented mode it is ignored.

Mode fields and sync patterns are captured only while the receiver is disabled. The SYNC input is assumed to be already synchronous to the receive clock.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, and on every clock while `rx_en_i` is low, the block is in the following state: `hunt_o` is 1, `char_vld_o` is 0 and `sync_out_o` is 1. No interrupt is pending after reset.
- R2: Async mode is selected with `proto_i` = 00. In this mode a change of `sync_in_i` in either direction, seen while no interrupt is pending, is copied to `pin_lvl_o` and sets `es_irq_o` at the same clock edge.
- R3: While `es_irq_o` is set, further `sync_in_i` changes leave `pin_lvl_o` unchanged. `es_irq_o` stays set until a clock with `rst_es_i` high clears it.
- R4: Internal monosync is selected with `proto_i` = 01 and `stype_i` = 00. Bits are assembled LSB first, so the first received bit lands in bit 0. The hunt ends when the last 8 bits received equal `sync1_i` and at least 8 bits have arrived since the hunt began. At that edge `hunt_o` falls and `sync_out_o` goes low for exactly one clock, with `sync_oe_o` high in this mode.
- R5: Bisync is selected with `stype_i` = 01. The hunt ends only when the `sync1_i` character is received and the `sync2_i` character follows it immediately. A single extra bit between the two characters prevents the match.
- R6: After internal sync, each following group of 8 bits is presented on `char_o`, first bit in bit 0, with `char_vld_o` high for one clock.
- R7: After internal sync, a character boundary that completes a sync pattern pulses `sync_out_o` low again. In monosync the pattern is `sync1_i`. In bisync it is `sync2_i` preceded by a `sync1_i` character.
- R8: An enter-hunt command (`hunt_cmd_i`) arriving while `sync_out_o` is low has no effect. Otherwise, in any mode except async, it sets `hunt_o` and empties the match window, which also drops the bit arriving on that clock.
- R9: External sync is selected with `stype_i` = 1x. A clock that samples `sync_in_i` low, after the previous clock sampled it high, ends the hunt. The bit received at that previous clock becomes bit 0 of the first character.
- R10: In external sync, `sync_in_i` sampled high while synchronized returns the block to the hunt.
- R11: In bit-oriented mode (`proto_i` = 1x), `sync_in_i` is ignored, `sync_oe_o` stays 0, no interrupt is raised and no characters are produced. The interrupt is raised in async mode only.
- R12: `proto_i`, `stype_i`, `sync1_i` and `sync2_i` are captured only while `rx_en_i` is low. Changes to them while the receiver is enabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable; low reloads configuration and forces hunt |
| proto_i | input | 2 | Protocol: 00 async, 01 character sync, 1x bit-oriented |
| stype_i | input | 2 | Sync type: 00 mono, 01 bisync, 1x external |
| sync1_i | input | 8 | First sync pattern |
| sync2_i | input | 8 | Second sync pattern (bisync) |
| rxd_i | input | 1 | Serial receive data |
| hunt_cmd_i | input | 1 | Enter-hunt command |
| rst_es_i | input | 1 | Clear external/status interrupt |
| sync_in_i | input | 1 | SYNC pin input level |
| sync_out_o | output | 1 | SYNC pin drive value (active low) |
| sync_oe_o | output | 1 | SYNC pin output enable |
| hunt_o | output | 1 | Hunt phase active |
| pin_lvl_o | output | 1 | Latched SYNC level (async status) |
| es_irq_o | output | 1 | External/status interrupt request |
| char_o | output | 8 | Assembled character |
| char_vld_o | output | 1 | Character strobe |

## Verification
The bench builds the block with its defaults: an 8-bit character, which gives a 16-bit match window, and a two-stage reset release. With that window a single sync byte and a full bisync pair can be sent bit by bit. The same setup also covers the extra-bit bisync pattern, the back-dated first character in external sync, and the enter-hunt lockout during the one-clock SYNC pulse. Every clock is compared against a queue-based model, alongside directed checks at the edges each requirement names.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    PR_ASYNC = 2'b00,
    PR_CHAR  = 2'b01,
    PR_BIT   = 2'b10,
    PR_BIT2  = 2'b11
  } proto_e;

  typedef enum logic [1:0] {
    ST_MONO = 2'b00,
    ST_BI   = 2'b01,
    ST_EXT  = 2'b10,
    ST_EXT2 = 2'b11
  } stype_e;

  typedef struct packed {
    proto_e proto;
    stype_e stype;
  } mode_t;
endpackage

// File: rtl/shr_rst_sync.sv
module shr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 1'b0;
    else         stg_q[0] <= 1'b1;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign rst_no = stg_q[STAGES-1];
endmodule

// File: rtl/shr_win_match.sv
// Two-character window, newest bit entering at the top, with a fill count.
// Hits are computed on the next window value so they line up with the edge.
module shr_win_match #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic              bit_i,
  input  logic [CHAR_W-1:0] pat_a_i,
  input  logic [CHAR_W-1:0] pat_b_i,
  output logic [CHAR_W-1:0] last_o,
  output logic              one_hit_o,
  output logic              two_hit_o
);
  localparam int WIN_W  = 2 * CHAR_W;
  localparam int FILL_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [FILL_W-1:0] fill_q, fill_d;

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (clear_i) begin
      win_d  = '0;
      fill_d = '0;
    end else if (shift_i) begin
      win_d = {bit_i, win_q[WIN_W-1:1]};
      if (fill_q != FILL_W'(WIN_W)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  assign last_o    = win_d[WIN_W-1:CHAR_W];
  assign one_hit_o = (fill_d >= FILL_W'(CHAR_W)) && (win_d[WIN_W-1:CHAR_W] == pat_a_i);
  assign two_hit_o = (fill_d == FILL_W'(WIN_W)) && (win_d[CHAR_W-1:0] == pat_a_i)
                     && (win_d[WIN_W-1:CHAR_W] == pat_b_i);
endmodule

// File: rtl/shr_pin_watch.sv
// Level latch and interrupt for the SYNC pin as a status input.
module shr_pin_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic watch_i,
  input  logic pin_i,
  input  logic ack_i,
  output logic lvl_o,
  output logic irq_o,
  output logic prev_o
);
  logic lvl_q, lvl_d, irq_q, irq_d, prev_q;

  always_comb begin
    irq_d = irq_q;
    lvl_d = lvl_q;
    if (ack_i) irq_d = 1'b0;
    if (!watch_i) begin
      lvl_d = pin_i;
    end else if (!irq_q && (pin_i != lvl_q)) begin
      lvl_d = pin_i;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      irq_q  <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      lvl_q  <= lvl_d;
      irq_q  <= irq_d;
      prev_q <= pin_i;
    end
  end

  assign lvl_o  = lvl_q;
  assign irq_o  = irq_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import shr_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [1:0]        proto_i,
  input  logic [1:0]        stype_i,
  input  logic [CHAR_W-1:0] sync1_i,
  input  logic [CHAR_W-1:0] sync2_i,
  input  logic              rxd_i,
  input  logic              hunt_cmd_i,
  input  logic              rst_es_i,
  input  logic              sync_in_i,
  output logic              sync_out_o,
  output logic              sync_oe_o,
  output logic              hunt_o,
  output logic              pin_lvl_o,
  output logic              es_irq_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_vld_o
);
  localparam int POS_W = $clog2(CHAR_W);
  // External sync: the bit before the strobe and the strobe bit are both in.
  localparam logic [POS_W-1:0] EXT_START = POS_W'(2);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CHAR_W - 1);

  logic rst_n;
  shr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  // Configuration capture, enabled only while the receiver is off.
  mode_t             cfg_q, cfg_d;
  logic [CHAR_W-1:0] pa_q, pa_d, pb_q, pb_d;

  always_comb begin
    cfg_d = cfg_q;
    pa_d  = pa_q;
    pb_d  = pb_q;
    if (!rx_en_i) begin
      cfg_d.proto = proto_e'(proto_i);
      cfg_d.stype = stype_e'(stype_i);
      pa_d        = sync1_i;
      pb_d        = sync2_i;
    end
  end

  logic is_async, is_char, is_int, is_ext, is_bi, watch;
  assign is_async = (cfg_q.proto == PR_ASYNC);
  assign is_char  = (cfg_q.proto == PR_CHAR);
  assign is_int   = is_char && !cfg_q.stype[1];
  assign is_ext   = is_char && cfg_q.stype[1];
  assign is_bi    = (cfg_q.stype == ST_BI);
  assign watch    = rx_en_i && is_async;

  // Pin status path
  logic pin_prev;
  shr_pin_watch u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .watch_i(watch),
    .pin_i  (sync_in_i),
    .ack_i  (rst_es_i),
    .lvl_o  (pin_lvl_o),
    .irq_o  (es_irq_o),
    .prev_o (pin_prev)
  );

  // Hunt and framing state
  logic              hunt_q, hunt_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              pulse_q, pulse_d;
  logic              vld_q, vld_d;
  logic [CHAR_W-1:0] char_q, char_d;
  logic              take, win_clr, win_shift, hit, one_hit, two_hit, at_end;
  logic [CHAR_W-1:0] last_chr;

  assign take      = rx_en_i && hunt_cmd_i && !pulse_q && !is_async;
  assign win_clr   = !rx_en_i || take;
  assign win_shift = rx_en_i && is_char;

  shr_win_match #(.CHAR_W(CHAR_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .shift_i  (win_shift),
    .clear_i  (win_clr),
    .bit_i    (rxd_i),
    .pat_a_i  (pa_q),
    .pat_b_i  (pb_q),
    .last_o   (last_chr),
    .one_hit_o(one_hit),
    .two_hit_o(two_hit)
  );

  assign hit    = is_bi ? two_hit : one_hit;
  assign at_end = (pos_q == POS_LAST);

  always_comb begin
    hunt_d  = hunt_q;
    pos_d   = pos_q;
    pulse_d = 1'b0;
    vld_d   = 1'b0;
    char_d  = char_q;
    if (!rx_en_i || take) begin
      hunt_d = 1'b1;
      pos_d  = '0;
    end else if (is_int) begin
      if (hunt_q) begin
        if (hit) begin
          hunt_d  = 1'b0;
          pos_d   = '0;
          pulse_d = 1'b1;
        end
      end else if (at_end) begin
        vld_d   = 1'b1;
        char_d  = last_chr;
        pos_d   = '0;
        pulse_d = hit;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end else if (is_ext) begin
      if (hunt_q) begin
        if (!sync_in_i && pin_prev) begin
          hunt_d = 1'b0;
          pos_d  = EXT_START;
        end
      end else if (sync_in_i) begin
        hunt_d = 1'b1;
        pos_d  = '0;
      end else if (at_end) begin
        vld_d  = 1'b1;
        char_d = last_chr;
        pos_d  = '0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      hunt_q  <= 1'b1;
      pos_q   <= '0;
      pulse_q <= 1'b0;
      vld_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      cfg_q   <= cfg_d;
      pa_q    <= pa_d;
      pb_q    <= pb_d;
      hunt_q  <= hunt_d;
      pos_q   <= pos_d;
      pulse_q <= pulse_d;
      vld_q   <= vld_d;
      char_q  <= char_d;
    end
  end

  assign sync_oe_o  = is_int;
  assign sync_out_o = !pulse_q;
  assign hunt_o     = hunt_q;
  assign char_o     = char_q;
  assign char_vld_o = vld_q;
endmodule

// File: rtl/shr_hunt_chk.sv
module shr_hunt_chk (
  input logic clk_i,
  input logic rst_n,
  input logic rx_en_i,
  input logic hunt_cmd_i,
  input logic rst_es_i,
  input logic watch,
  input logic sync_out_o,
  input logic sync_oe_o,
  input logic hunt_o,
  input logic pin_lvl_o,
  input logic es_irq_o,
  input logic char_vld_o
);
  AST_PULSE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sync_out_o |=> sync_out_o); // R4
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sync_out_o |-> sync_oe_o); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    es_irq_o && !rst_es_i |=> es_irq_o); // R3
  AST_LVL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    es_irq_o && watch |=> $stable(pin_lvl_o)); // R3
  AST_IRQ_ASYNC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(es_irq_o) |-> $past(watch)); // R11
  AST_HUNT_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sync_out_o && hunt_cmd_i && rx_en_i |=> !hunt_o); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    char_vld_o |=> !char_vld_o); // R6
  AST_STROBE_SYNCED: assert property (@(posedge clk_i) disable iff (!rst_n)
    char_vld_o |-> !hunt_o); // R6
  AST_DISABLED_HUNT: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rx_en_i |=> hunt_o && !char_vld_o); // R1
endmodule

bind sync_hunt_rx shr_hunt_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .rx_en_i   (rx_en_i),
  .hunt_cmd_i(hunt_cmd_i),
  .rst_es_i  (rst_es_i),
  .watch     (watch),
  .sync_out_o(sync_out_o),
  .sync_oe_o (sync_oe_o),
  .hunt_o    (hunt_o),
  .pin_lvl_o (pin_lvl_o),
  .es_irq_o  (es_irq_o),
  .char_vld_o(char_vld_o)
);

// File: tb/tb_sync_hunt_rx.sv
`timescale 1ns/1ps
module tb_sync_hunt_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni, rx_en, rxd, hunt_cmd, rst_es, sync_in;
  logic [1:0] proto, stype;
  logic [7:0] s1, s2;
  logic       sync_out, sync_oe, hunt, lvl, irq, vld;
  logic [7:0] chr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en), .proto_i(proto), .stype_i(stype),
    .sync1_i(s1), .sync2_i(s2), .rxd_i(rxd), .hunt_cmd_i(hunt_cmd), .rst_es_i(rst_es),
    .sync_in_i(sync_in), .sync_out_o(sync_out), .sync_oe_o(sync_oe), .hunt_o(hunt),
    .pin_lvl_o(lvl), .es_irq_o(irq), .char_o(chr), .char_vld_o(vld)
  );

  // ---------------- behavioural reference model ----------------
  bit [1:0] m_proto = 0, m_st = 0;
  bit [7:0] m_s1 = 0, m_s2 = 0, m_char = 0;
  bit       m_hunt = 1, m_pulse = 0, m_vld = 0, m_lvl = 1, m_irq = 0, m_prev = 1;
  int       m_pos = 0;
  bit       win[$];

  function automatic bit [7:0] qbyte(int start);
    bit [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = win[start + i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_proto = 0; m_st = 0; m_s1 = 0; m_s2 = 0; m_char = 0;
      m_hunt = 1; m_pulse = 0; m_vld = 0; m_lvl = 1; m_irq = 0; m_prev = 1;
      m_pos = 0; win.delete();
    end else begin
      bit asy, chm, intl, ext, take, match, new_irq, pulse_n;
      asy  = (m_proto == 2'b00);
      chm  = (m_proto == 2'b01);
      intl = chm && !m_st[1];
      ext  = chm && m_st[1];
      take = rx_en && hunt_cmd && !m_pulse && !asy;
      new_irq = rst_es ? 1'b0 : m_irq;
      if (!(rx_en && asy)) m_lvl = sync_in;
      else if (!m_irq && sync_in != m_lvl) begin m_lvl = sync_in; new_irq = 1'b1; end
      m_irq = new_irq;
      if (!rx_en || take) win.delete();
      else if (chm) begin
        win.push_back(rxd);
        if (win.size() > 16) void'(win.pop_front());
      end
      if (m_st == 2'b01)
        match = (win.size() == 16) && qbyte(0) == m_s1 && qbyte(8) == m_s2;
      else
        match = (win.size() >= 8) && qbyte(win.size() - 8) == m_s1;
      pulse_n = 1'b0;
      m_vld   = 1'b0;
      if (!rx_en || take) begin
        m_hunt = 1; m_pos = 0;
      end else if (intl) begin
        if (m_hunt) begin
          if (match) begin m_hunt = 0; m_pos = 0; pulse_n = 1; end
        end else if (m_pos == 7) begin
          m_vld = 1; m_char = qbyte(win.size() - 8); m_pos = 0; pulse_n = match;
        end else m_pos++;
      end else if (ext) begin
        if (m_hunt) begin
          if (!sync_in && m_prev) begin m_hunt = 0; m_pos = 2; end
        end else if (sync_in) begin
          m_hunt = 1; m_pos = 0;
        end else if (m_pos == 7) begin
          m_vld = 1; m_char = qbyte(win.size() - 8); m_pos = 0;
        end else m_pos++;
      end
      m_pulse = pulse_n;
      m_prev  = sync_in;
      if (!rx_en) begin m_proto = proto; m_st = stype; m_s1 = s1; m_s2 = s2; end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(hunt == m_hunt, "R4", "hunt_o vs model", hunt, m_hunt);
    chk(lvl == m_lvl, "R2", "pin_lvl_o vs model", lvl, m_lvl);
    chk(irq == m_irq, "R3", "es_irq_o vs model", irq, m_irq);
    chk(sync_out == !m_pulse, "R7", "sync_out_o vs model", sync_out, !m_pulse);
    chk(sync_oe == (m_proto == 2'b01 && !m_st[1]), "R11", "sync_oe_o vs model",
        sync_oe, (m_proto == 2'b01 && !m_st[1]));
    chk(vld == m_vld, "R6", "char_vld_o vs model", vld, m_vld);
    if (m_vld) chk(chr == m_char, "R6", "char_o vs model", chr, m_char);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      tick();
    end
  endtask

  task automatic setup(input logic [1:0] p, input logic [1:0] t,
                       input logic [7:0] a, input logic [7:0] b);
    rx_en = 0; proto = p; stype = t; s1 = a; s2 = b;
    tick(); tick();
    rx_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; rx_en = 0; rxd = 1; hunt_cmd = 0; rst_es = 0; sync_in = 1;
    proto = 2'b00; stype = 2'b00; s1 = 8'h00; s2 = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (5) tick();
    chk(hunt == 1, "R1", "hunt_o after reset", hunt, 1);
    chk(irq == 0, "R1", "es_irq_o after reset", irq, 0);
    chk(sync_out == 1, "R1", "sync_out_o after reset", sync_out, 1);
    chk(vld == 0, "R1", "char_vld_o after reset", vld, 0);

    // R2 / R3: async status pin
    rx_en = 1; tick();
    sync_in = 0; tick();
    chk(irq == 1, "R2", "irq on falling pin", irq, 1);
    chk(lvl == 0, "R2", "level latched low", lvl, 0);
    sync_in = 1; tick();
    chk(lvl == 0, "R3", "level frozen while pending", lvl, 0);
    rst_es = 1; tick(); rst_es = 0;
    chk(irq == 0, "R3", "irq cleared", irq, 0);
    tick();
    chk(irq == 1, "R2", "irq on rising pin", irq, 1);
    chk(lvl == 1, "R2", "level latched high", lvl, 1);
    rst_es = 1; tick(); rst_es = 0; tick();

    // R4 / R6 / R7 / R8: monosync
    setup(2'b01, 2'b00, 8'h16, 8'h68);
    chk(sync_oe == 1, "R4", "oe in internal mode", sync_oe, 1);
    send_bits(8'hFF, 8); send_bits(8'hFF, 8);
    chk(hunt == 1, "R4", "still hunting", hunt, 1);
    send_bits(8'h16, 8);
    chk(hunt == 0, "R4", "hunt exit on sync1", hunt, 0);
    chk(sync_out == 0, "R4", "sync pulse low", sync_out, 0);
    hunt_cmd = 1; send_bits(8'h3C, 1); hunt_cmd = 0;
    chk(hunt == 0, "R8", "enter-hunt ignored during pulse", hunt, 0);
    chk(sync_out == 1, "R4", "pulse one clock", sync_out, 1);
    send_bits(8'h3C >> 1, 7);
    chk(vld == 1 && chr == 8'h3C, "R6", "first framed char", chr, 8'h3C);
    send_bits(8'h16, 8);
    chk(vld == 1 && chr == 8'h16, "R6", "sync char framed", chr, 8'h16);
    chk(sync_out == 0, "R7", "pulse at boundary", sync_out, 0);
    tick();
    hunt_cmd = 1; tick(); hunt_cmd = 0;
    chk(hunt == 1, "R8", "enter-hunt accepted", hunt, 1);
    send_bits(8'h16, 4);
    hunt_cmd = 1; send_bits(8'h16 >> 4, 1); hunt_cmd = 0;
    send_bits(8'h16 >> 5, 3);
    chk(hunt == 1, "R8", "window emptied by enter-hunt", hunt, 1);
    s1 = 8'hFF; proto = 2'b00;
    send_bits(8'h16, 8);
    chk(hunt == 0, "R12", "latched sync1 still used", hunt, 0);
    chk(sync_oe == 1, "R12", "mode unchanged while enabled", sync_oe, 1);

    // R5 / R7: bisync
    setup(2'b01, 2'b01, 8'h16, 8'h68);
    send_bits(8'hFF, 8); send_bits(8'h16, 8); send_bits(8'h00, 1);
    send_bits(8'h68, 8); send_bits(8'hFF, 8);
    chk(hunt == 1, "R5", "extra bit blocks bisync", hunt, 1);
    send_bits(8'h16, 8);
    chk(hunt == 1, "R5", "sync1 alone not enough", hunt, 1);
    send_bits(8'h68, 8);
    chk(hunt == 0, "R5", "bisync pair found", hunt, 0);
    chk(sync_out == 0, "R5", "bisync pulse", sync_out, 0);
    send_bits(8'h16, 8);
    chk(sync_out == 1, "R7", "no pulse on sync1 char", sync_out, 1);
    send_bits(8'h68, 8);
    chk(vld == 1 && chr == 8'h68, "R6", "bisync framed char", chr, 8'h68);
    chk(sync_out == 0, "R7", "pulse on pair at boundary", sync_out, 0);

    // R9 / R10: external sync
    sync_in = 1;
    setup(2'b01, 2'b10, 8'h16, 8'h68);
    chk(sync_oe == 0, "R9", "no drive in external mode", sync_oe, 0);
    send_bits(8'hFF, 8);
    chk(hunt == 1, "R9", "high level keeps hunt", hunt, 1);
    send_bits(8'hC5, 1);
    sync_in = 0; send_bits(8'hC5 >> 1, 1);
    chk(hunt == 0, "R9", "falling strobe ends hunt", hunt, 0);
    send_bits(8'hC5 >> 2, 6);
    chk(vld == 1 && chr == 8'hC5, "R9", "back-dated first char", chr, 8'hC5);
    send_bits(8'h5A, 8);
    chk(vld == 1 && chr == 8'h5A, "R9", "second char while low", chr, 8'h5A);
    sync_in = 1; tick();
    chk(hunt == 1, "R10", "sync lost on high pin", hunt, 1);

    // R11: bit-oriented
    setup(2'b10, 2'b00, 8'h16, 8'h68);
    sync_in = 0; tick(); sync_in = 1; tick();
    chk(irq == 0, "R11", "pin ignored, no irq", irq, 0);
    chk(sync_oe == 0, "R11", "no drive in bit mode", sync_oe, 0);
    hunt_cmd = 1; tick(); hunt_cmd = 0;
    send_bits(8'h16, 8);
    chk(hunt == 1 && vld == 0, "R11", "no sync/no chars", {hunt, vld}, 2'b10);
    rx_en = 0; tick();
    chk(hunt == 1 && vld == 0, "R1", "disabled state", {hunt, vld}, 2'b10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule